// File: doc/BRIEF.md
# Precise Pipeline Trap Controller

This block sits beside an in-order pipeline and decides, every cycle, whether control flow must leave the running program. Each stage may raise a trap request carrying the PC of its instruction and a cause code, and an external interrupt line may also be asserted. When one or more stage requests are present, the request from the oldest instruction wins. The winning instruction and every younger instruction are squashed through per-stage flush outputs, and fetch is redirected to the trap handler in the same cycle. One clock later the saved return address (the faulting PC plus four) and the cause code are visible on their register outputs.

The handler entry is picked at elaboration time. It is either one fixed entry at 0x8000_0180, or a vector table at 0xC000_0000 whose entries are spaced 0x20 apart and indexed by cause. An interrupt has lower priority than any synchronous trap. It is taken at the fetch boundary with its own cause code. Once a trap is taken, the saved registers are frozen and further requests are ignored until a return-from-trap pulse arrives. That pulse sends fetch back to the saved address.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the saved-PC output and the cause output read 0. With no request, no interrupt and no return, redirect and every flush bit are 0.
- R2: Stage index 0 is fetch, 1 decode, 2 execute and 3 memory; a higher index holds an older instruction. When several stages request in one cycle, the highest-indexed request is the one taken.
- R3: When stage k is taken, flush bits 0 through k are 1 in that cycle and all higher bits are 0, so older instructions complete.
- R4: On a taken trap, the saved-PC output shows the winning PC plus 4 from the next cycle on, and the cause output shows the winning cause code. Cause 0 means undefined opcode and cause 1 means arithmetic overflow.
- R5: In fixed-entry mode (VECTORED=0), a taken trap asserts redirect in the same cycle with target 0x8000_0180.
- R6: In vectored mode (VECTORED=1), the target is 0xC000_0000 + cause*0x20, so cause 0 goes to 0xC000_0000 and cause 1 to 0xC000_0020.
- R7: An interrupt is taken only when no stage requests. It flushes only bit 0, saves the boundary PC plus 4, and records cause IRQ_CAUSE (default 12).
- R8: While a trap is being handled (after one is taken and before the return), stage requests and the interrupt are ignored: no redirect, no flush, and the saved PC and cause hold.
- R9: A return pulse while handling redirects to the saved PC, flushes only bit 0, and ends handling. A return pulse while not handling does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_req | input | NST | Per-stage trap request, index 0 = fetch |
| stg_pc | input | NST*32 | Per-stage instruction PC, stage s at bits [s*32 +: 32] |
| stg_cause | input | NST*CW | Per-stage cause code, stage s at bits [s*CW +: CW] |
| irq | input | 1 | External interrupt request |
| irq_pc | input | 32 | PC at the fetch boundary where an interrupt lands |
| tret | input | 1 | Return-from-trap pulse |
| flush | output | NST | Per-stage squash |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Fetch redirect target |
| saved_pc | output | 32 | Saved return address (PC + 4) |
| saved_cause | output | CW | Saved cause code |

## Verification
The bench aims first at simultaneous requests from several stages. A design with reversed priority would record the younger PC and squash an older instruction that should have retired. It checks that the flush mask stops exactly at the winning stage. An off-by-one there would drop the faulting instruction or kill an older one. It runs interrupts alone and together with a stage request, because a wrong priority would let an asynchronous event overtake a precise fault. Finally it raises new requests during handling and return pulses while idle, where a missing guard shows up as an overwritten saved PC or a spurious redirect.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int AW = 32;
  typedef logic [AW-1:0] addr_t;

  // Return address stored on a trap: the trapping PC advanced by one word.
  function automatic addr_t ret_addr(input addr_t pc);
    return pc + addr_t'(4);
  endfunction

  // Vectored handler entry: base plus cause times the entry spacing.
  function automatic addr_t vec_entry(input addr_t base, input addr_t stride,
                                      input logic [7:0] code);
    return base + stride * addr_t'(code);
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int NST = 4,
  parameter int CW = 5,
  parameter logic [CW-1:0] IRQ_CAUSE = CW'(12)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [NST-1:0]    req,
  input  logic [NST*AW-1:0] pc_flat,
  input  logic [NST*CW-1:0] cause_flat,
  input  logic              irq,
  input  addr_t             irq_pc,
  output logic              take,
  output addr_t             sel_pc,
  output logic [CW-1:0]     sel_cause,
  output logic [NST-1:0]    kill_mask
);
  localparam int IW = $clog2(NST) + 1;

  addr_t           pc_a    [NST];
  logic [CW-1:0]   cause_a [NST];
  logic            any_req;
  logic [IW-1:0]   win;

  genvar g;
  generate
    for (g = 0; g < NST; g++) begin : g_unpack
      assign pc_a[g]    = pc_flat[g*AW +: AW];
      assign cause_a[g] = cause_flat[g*CW +: CW];
    end
  endgenerate

  // Ascending scan: the last hit is the oldest requesting stage.
  always_comb begin
    any_req = 1'b0;
    win     = '0;
    for (int i = 0; i < NST; i++) begin
      if (req[i]) begin
        any_req = 1'b1;
        win     = IW'(i);
      end
    end
  end

  always_comb begin
    take      = 1'b0;
    sel_pc    = '0;
    sel_cause = '0;
    kill_mask = '0;
    if (enable) begin
      if (any_req) begin
        take      = 1'b1;
        sel_pc    = pc_a[win[IW-2:0]];
        sel_cause = cause_a[win[IW-2:0]];
        for (int i = 0; i < NST; i++)
          kill_mask[i] = (IW'(i) <= win);
      end else if (irq) begin
        take      = 1'b1;
        sel_pc    = irq_pc;
        sel_cause = IRQ_CAUSE;
        kill_mask = NST'(1);
      end
    end
  end

  // Squash mask is always a contiguous run starting at bit 0.
  p_flush_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kill_mask + NST'(1)));
  // A younger request never beats an older one.
  p_oldest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req[NST-1]) |-> kill_mask[NST-1]);
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter int    CW         = 5,
  parameter bit    VECTORED   = 1'b0,
  parameter addr_t FIXED_BASE = 32'h8000_0180,
  parameter addr_t VEC_BASE   = 32'hC000_0000,
  parameter addr_t VEC_STEP   = 32'h0000_0020
) (
  input  logic [CW-1:0] cause,
  output addr_t         entry
);
  generate
    if (VECTORED) begin : g_vec
      assign entry = vec_entry(VEC_BASE, VEC_STEP, 8'(cause));
    end else begin : g_fixed
      assign entry = FIXED_BASE;
    end
  endgenerate
endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  addr_t         take_pc,
  input  logic [CW-1:0] take_cause,
  input  logic          tret,
  output logic          busy,
  output logic          ret_fire,
  output addr_t         epc_q,
  output logic [CW-1:0] cause_q
);
  assign ret_fire = busy && tret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      epc_q   <= '0;
      cause_q <= '0;
    end else if (take) begin
      busy    <= 1'b1;
      epc_q   <= ret_addr(take_pc);
      cause_q <= take_cause;
    end else if (ret_fire) begin
      busy    <= 1'b0;
    end
  end

  p_take_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);
  p_hold_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tret) |=> ($stable(epc_q) && $stable(cause_q)));
  p_ret_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> !busy);
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int    NST        = 4,
  parameter int    CW         = 5,
  parameter bit    VECTORED   = 1'b0,
  parameter logic [CW-1:0] IRQ_CAUSE = CW'(12),
  parameter addr_t FIXED_BASE = 32'h8000_0180,
  parameter addr_t VEC_BASE   = 32'hC000_0000,
  parameter addr_t VEC_STEP   = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NST-1:0]    stg_req,
  input  logic [NST*32-1:0] stg_pc,
  input  logic [NST*CW-1:0] stg_cause,
  input  logic              irq,
  input  logic [31:0]       irq_pc,
  input  logic              tret,
  output logic [NST-1:0]    flush,
  output logic              redirect,
  output logic [31:0]       redirect_pc,
  output logic [31:0]       saved_pc,
  output logic [CW-1:0]     saved_cause
);
  logic            busy;
  logic            take;
  logic            ret_fire;
  addr_t           sel_pc;
  logic [CW-1:0]   sel_cause;
  logic [NST-1:0]  kill_mask;
  addr_t           entry;

  trap_arbiter #(.NST(NST), .CW(CW), .IRQ_CAUSE(IRQ_CAUSE)) u_arb (
    .clk(clk), .rst_n(rst_n), .enable(!busy),
    .req(stg_req), .pc_flat(stg_pc), .cause_flat(stg_cause),
    .irq(irq), .irq_pc(irq_pc),
    .take(take), .sel_pc(sel_pc), .sel_cause(sel_cause), .kill_mask(kill_mask)
  );

  trap_vector #(.CW(CW), .VECTORED(VECTORED), .FIXED_BASE(FIXED_BASE),
                .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_vec (
    .cause(sel_cause), .entry(entry)
  );

  trap_state #(.CW(CW)) u_st (
    .clk(clk), .rst_n(rst_n), .take(take), .take_pc(sel_pc),
    .take_cause(sel_cause), .tret(tret), .busy(busy), .ret_fire(ret_fire),
    .epc_q(saved_pc), .cause_q(saved_cause)
  );

  always_comb begin
    redirect    = take || ret_fire;
    redirect_pc = '0;
    flush       = '0;
    if (take) begin
      redirect_pc = entry;
      flush       = kill_mask;
    end else if (ret_fire) begin
      redirect_pc = saved_pc;
      flush       = NST'(1);
    end
  end

  p_quiet_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tret) |-> (!redirect && flush == '0));
  p_ret_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |-> (redirect_pc == saved_pc));
  p_entry_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (redirect_pc[4:0] == 5'd0));
endmodule

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;
  localparam int NST = 4;
  localparam int CW  = 5;
  localparam int NV  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NST-1:0]    stg_req = '0;
  logic [NST*32-1:0] stg_pc;
  logic [NST*CW-1:0] stg_cause = '0;
  logic              irq = 1'b0;
  logic [31:0]       irq_pc = 32'h0000_0200;
  logic              tret = 1'b0;
  logic [NST-1:0]    flush, flush_v;
  logic              redirect, redirect_v;
  logic [31:0]       redirect_pc, redirect_pc_v, saved_pc, saved_pc_v;
  logic [CW-1:0]     saved_cause, saved_cause_v;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  trap_ctrl #(.NST(NST), .CW(CW), .VECTORED(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .stg_req(stg_req), .stg_pc(stg_pc),
    .stg_cause(stg_cause), .irq(irq), .irq_pc(irq_pc), .tret(tret),
    .flush(flush), .redirect(redirect), .redirect_pc(redirect_pc),
    .saved_pc(saved_pc), .saved_cause(saved_cause));

  trap_ctrl #(.NST(NST), .CW(CW), .VECTORED(1'b1)) uut_v (
    .clk(clk), .rst_n(rst_n), .stg_req(stg_req), .stg_pc(stg_pc),
    .stg_cause(stg_cause), .irq(irq), .irq_pc(irq_pc), .tret(tret),
    .flush(flush_v), .redirect(redirect_v), .redirect_pc(redirect_pc_v),
    .saved_pc(saved_pc_v), .saved_cause(saved_cause_v));

  // Older stage (higher index) holds the smaller PC.
  function automatic logic [31:0] pc_of(input int s);
    return 32'h0000_0040 + 32'(4 * (NST - 1 - s));
  endfunction

  initial for (int s = 0; s < NST; s++) stg_pc[s*32 +: 32] = pc_of(s);

  // Vectors: request mask, causes {s3,s2,s1,s0}, irq, expected winner
  // (-1 none, 4 interrupt), expected flush mask.
  localparam logic [3:0]  V_REQ  [NV] = '{4'b0100, 4'b0110, 4'b1111, 4'b0001,
                                          4'b0000, 4'b0010, 4'b1010, 4'b0000};
  localparam logic [19:0] V_CAU  [NV] = '{{5'd0,5'd1,5'd0,5'd0},
                                          {5'd0,5'd1,5'd0,5'd0},
                                          {5'd0,5'd1,5'd1,5'd1},
                                          {5'd0,5'd0,5'd0,5'd3},
                                          {5'd0,5'd0,5'd0,5'd0},
                                          {5'd0,5'd0,5'd1,5'd0},
                                          {5'd2,5'd0,5'd1,5'd0},
                                          {5'd0,5'd0,5'd0,5'd0}};
  localparam logic        V_IRQ  [NV] = '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0};
  localparam int          V_WIN  [NV] = '{2, 2, 3, 0, 4, 1, 3, -1};
  localparam logic [3:0]  V_FL   [NV] = '{4'b0111, 4'b0111, 4'b1111, 4'b0001,
                                          4'b0001, 4'b0011, 4'b1111, 4'b0000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] e_pc;
    logic [CW-1:0] e_cause;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 saved_pc", saved_pc, 32'h0);
    chk("R1 saved_cause", 32'(saved_cause), 32'h0);
    chk("R1 redirect", 32'(redirect), 32'h0);
    chk("R1 flush", 32'(flush), 32'h0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      stg_req = V_REQ[v];
      stg_cause = V_CAU[v];
      irq = V_IRQ[v];
      #1;
      chk(V_WIN[v] == 4 ? "R7 flush" : "R3 flush", 32'(flush), 32'(V_FL[v]));
      if (V_WIN[v] < 0) begin
        chk("R1 idle redirect", 32'(redirect), 32'h0);
        continue;
      end
      if (V_WIN[v] == 4) begin
        e_pc = irq_pc + 32'd4;
        e_cause = 5'd12;
      end else begin
        e_pc = pc_of(V_WIN[v]) + 32'd4;
        e_cause = V_CAU[v][V_WIN[v]*CW +: CW];
      end
      chk("R5 redirect", 32'(redirect), 32'h1);
      chk("R5 fixed entry", redirect_pc, 32'h8000_0180);
      chk("R6 vector entry", redirect_pc_v, 32'hC000_0000 + 32'(e_cause) * 32'd32);
      @(negedge clk);
      stg_req = '0; irq = 1'b0;
      #1;
      chk("R2 R4 saved_pc", saved_pc, e_pc);
      chk("R4 saved_cause", 32'(saved_cause), 32'(e_cause));
      @(negedge clk);
      tret = 1'b1;
      #1;
      chk("R9 ret redirect", 32'(redirect), 32'h1);
      chk("R9 ret target", redirect_pc, e_pc);
      chk("R9 ret flush", 32'(flush), 32'h1);
      @(negedge clk);
      tret = 1'b0;
      #1;
      chk("R9 idle after ret", 32'(redirect), 32'h0);
    end

    // R9: return pulse while idle is ignored.
    @(negedge clk);
    tret = 1'b1;
    #1;
    chk("R9 idle tret redirect", 32'(redirect), 32'h0);
    chk("R9 idle tret flush", 32'(flush), 32'h0);
    @(negedge clk);
    tret = 1'b0;

    // R8: new requests while handling are ignored.
    stg_req = 4'b0100; stg_cause = {5'd0, 5'd1, 5'd0, 5'd0};
    #1;
    chk("R4 overflow cause entry", redirect_pc_v, 32'hC000_0020);
    @(negedge clk);
    stg_req = 4'b1000; stg_cause = {5'd0, 5'd0, 5'd0, 5'd0}; irq = 1'b1;
    #1;
    chk("R8 no redirect", 32'(redirect), 32'h0);
    chk("R8 no flush", 32'(flush), 32'h0);
    @(negedge clk);
    stg_req = '0; irq = 1'b0;
    #1;
    chk("R8 saved_pc held", saved_pc, pc_of(2) + 32'd4);
    chk("R8 saved_cause held", 32'(saved_cause), 32'h1);
    @(negedge clk);
    tret = 1'b1;
    @(negedge clk);
    tret = 1'b0;

    // R1: reset clears saved state.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset saved_pc", saved_pc, 32'h0);
    chk("R1 reset saved_cause", 32'(saved_cause), 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule